// File: doc/BRIEF.md
# Dirty Band Update Coalescer

The coalescer keeps one dirty flag per framebuffer page, where each page covers a band of four display lines. Writers mark pages as they touch them. Pages can be marked in the 8-bit index plane, and in a deep-colour mode also in a direct-colour plane and a control plane. Those two planes each hold four pages per band. On a scan pulse the block walks the bands from top to bottom. It merges each run of dirty bands into one full-width update rectangle and hands the rectangle to a consumer over a valid/ready handshake.

While scanning, the block records the lowest and highest dirty band. When the walk ends it clears every flag inside that band range in one cycle. It then raises a done flag, which lets a display refresher run a scan once per frame and redraw only what changed. A full-invalidate input marks every page, so the next scan redraws the whole screen.

The control is a four-state machine:

- **IDLE** waits for `scan_start` and goes to **SCAN**.
- **SCAN** evaluates one band per cycle. It goes to **EMIT** when a run closes, either at a clean band or at the last band. It goes to **CLEAR** when the last band is reached with no run open.
- **EMIT** holds the rectangle until `rect_ready`. It then returns to **SCAN**, or goes to **CLEAR** if the rectangle was the final one.
- **CLEAR** performs the bulk clear, sets the done flag and returns to **IDLE**.

Top module: `dirty_band_coalescer`

## Requirements
- R1: Every page flag stands for exactly four display lines, so `rect_y` and `rect_h` are always multiples of 4 and `rect_h` is never zero.
- R2: A run of consecutive dirty bands closes at the first clean band. It is emitted as one rectangle with `rect_y` = 4 × first band and `rect_h` = 4 × number of bands in the run.
- R3: A run still open at the last band (band DISP_LINES/4 − 1) is emitted at the end of the scan and reaches line DISP_LINES.
- R4: Every rectangle has `rect_x` = 0 and `rect_w` = DISP_W.
- R5: After a scan, `range_valid` is 1 with `range_lo`/`range_hi` equal to the lowest/highest dirty band, or `range_valid` is 0 if no band was dirty.
- R6: After a scan, the index-plane flags of bands `range_lo`..`range_hi` are cleared. In deep mode, direct and control pages 4·`range_lo`..4·`range_hi`+3 are also cleared. Nothing is cleared when no band was dirty, and a base-mode scan leaves the direct and control planes untouched.
- R7: With `deep_mode` = 1 sampled at scan start, band b is dirty if index page b is marked, or if any of direct or control pages 4b..4b+3 is marked. With `deep_mode` = 0, only index page b counts.
- R8: A pulse on `invalidate` marks every page of every plane, so the next scan emits one rectangle with y = 0 and height DISP_LINES.
- R9: A `scan_start` pulse in IDLE begins a scan and clears `scan_done`. `scan_busy` is high until the clear step ends. `scan_done` then goes high and stays high until the next start. A `scan_start` while busy is ignored.
- R10: `rect_valid` stays high, with `rect_y`/`rect_h` unchanged, until a cycle with `rect_ready` high.
- R11: `mark_plane` encodes 0 = index plane, 1 = direct plane, 2 = control plane. Plane code 3 is ignored, and an index-plane `mark_page` of DISP_LINES/4 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deep_mode | input | 1 | Deep-colour mode, sampled at scan start |
| mark_valid | input | 1 | Mark one page dirty this cycle |
| mark_plane | input | 2 | Plane of the mark (0 index, 1 direct, 2 control) |
| mark_page | input | PGW | Page number within the plane |
| invalidate | input | 1 | Mark every page of every plane |
| scan_start | input | 1 | Start pulse for a scan |
| rect_valid | output | 1 | Update rectangle offered |
| rect_ready | input | 1 | Consumer accepts the rectangle |
| rect_x | output | WW | Rectangle left column (always 0) |
| rect_y | output | YW | Rectangle first line |
| rect_w | output | WW | Rectangle width (always DISP_W) |
| rect_h | output | YW | Rectangle height in lines |
| range_valid | output | 1 | A dirty range was found in the last scan |
| range_lo | output | BW | Lowest dirty band of the last scan |
| range_hi | output | BW | Highest dirty band of the last scan |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Last scan and its clear step finished |

## Verification
The assertions check the following on every cycle:

- Rectangles lie on the four-line grid and fit inside the display.
- A rectangle offered but not taken is held unchanged.
- The reported range is ordered.
- `scan_done` and `scan_busy` are never high together.
- An invalidate leaves every flag set.

Only the bench scenarios can show the rest: that runs split exactly at clean bands, that the range clear removes the right flags and leaves the other planes alone, that deep-mode plane combining works, and that a start pulse during a scan produces no extra rectangles. The bench shows these by scanning again and comparing against a scoreboard model.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_EMIT  = 2'd2,
        ST_CLEAR = 2'd3
    } scan_state_e;

    localparam logic [1:0] PL_INDEX  = 2'd0;
    localparam logic [1:0] PL_DIRECT = 2'd1;
    localparam logic [1:0] PL_CTRL   = 2'd2;
endpackage

// File: rtl/dbc_flag_store.sv
module dbc_flag_store
    import dbc_pkg::*;
#(
    parameter int BANDS = 16,
    parameter int BW    = 4,
    parameter int PGW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mark_valid,
    input  logic [1:0]           mark_plane,
    input  logic [PGW-1:0]       mark_page,
    input  logic                 invalidate,
    input  logic                 clr_en,
    input  logic                 clr_deep,
    input  logic [BW-1:0]        clr_lo,
    input  logic [BW-1:0]        clr_hi,
    output logic [BANDS-1:0]     index_flags,
    output logic [4*BANDS-1:0]   direct_flags,
    output logic [4*BANDS-1:0]   ctrl_flags
);
    localparam int PAGES = 4 * BANDS;

    // Priority: invalidate, then a mark, then the range clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_flags  <= '0;
            direct_flags <= '0;
            ctrl_flags   <= '0;
        end else begin
            for (int i = 0; i < BANDS; i++) begin
                if (invalidate)
                    index_flags[i] <= 1'b1;
                else if (mark_valid && mark_plane == PL_INDEX && mark_page == PGW'(i))
                    index_flags[i] <= 1'b1;
                else if (clr_en && BW'(i) >= clr_lo && BW'(i) <= clr_hi)
                    index_flags[i] <= 1'b0;
            end
            for (int j = 0; j < PAGES; j++) begin
                if (invalidate)
                    direct_flags[j] <= 1'b1;
                else if (mark_valid && mark_plane == PL_DIRECT && mark_page == PGW'(j))
                    direct_flags[j] <= 1'b1;
                else if (clr_en && clr_deep && BW'(j / 4) >= clr_lo && BW'(j / 4) <= clr_hi)
                    direct_flags[j] <= 1'b0;

                if (invalidate)
                    ctrl_flags[j] <= 1'b1;
                else if (mark_valid && mark_plane == PL_CTRL && mark_page == PGW'(j))
                    ctrl_flags[j] <= 1'b1;
                else if (clr_en && clr_deep && BW'(j / 4) >= clr_lo && BW'(j / 4) <= clr_hi)
                    ctrl_flags[j] <= 1'b0;
            end
        end
    end

    // R8: after an invalidate every flag of every plane is set
    p_invalidate_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> (&index_flags) && (&direct_flags) && (&ctrl_flags));
endmodule

// File: rtl/dbc_band_dirty.sv
module dbc_band_dirty #(
    parameter int BANDS = 16,
    parameter int BW    = 4
) (
    input  logic [BANDS-1:0]   index_flags,
    input  logic [4*BANDS-1:0] direct_flags,
    input  logic [4*BANDS-1:0] ctrl_flags,
    input  logic               deep,
    input  logic [BW-1:0]      band,
    output logic               band_dirty
);
    logic [BW+1:0] base_page;
    logic          wide_hit;

    assign base_page = {band, 2'b00};

    // R7: a deep band also counts its four direct and four control pages
    always_comb begin
        wide_hit   = (|direct_flags[base_page +: 4]) | (|ctrl_flags[base_page +: 4]);
        band_dirty = index_flags[band] | (deep & wide_hit);
    end
endmodule

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer
    import dbc_pkg::*;
#(
    parameter  int DISP_LINES = 64,
    parameter  int DISP_W     = 1024,
    localparam int BANDS      = DISP_LINES / 4,
    localparam int BW         = (BANDS > 1) ? $clog2(BANDS) : 1,
    localparam int PGW        = $clog2(4 * BANDS),
    localparam int YW         = $clog2(DISP_LINES + 1),
    localparam int WW         = $clog2(DISP_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           deep_mode,
    input  logic           mark_valid,
    input  logic [1:0]     mark_plane,
    input  logic [PGW-1:0] mark_page,
    input  logic           invalidate,
    input  logic           scan_start,
    output logic           rect_valid,
    input  logic           rect_ready,
    output logic [WW-1:0]  rect_x,
    output logic [YW-1:0]  rect_y,
    output logic [WW-1:0]  rect_w,
    output logic [YW-1:0]  rect_h,
    output logic           range_valid,
    output logic [BW-1:0]  range_lo,
    output logic [BW-1:0]  range_hi,
    output logic           scan_busy,
    output logic           scan_done
);
    scan_state_e state_q, state_d;

    logic [BW-1:0]      band_q, run_start_q, lo_q, hi_q;
    logic               run_open_q, any_q, deep_q, last_q, done_q;
    logic [YW-1:0]      rect_y_q, rect_h_q;
    logic               band_dirty, at_last, clr_en;
    logic [BANDS-1:0]   index_flags;
    logic [4*BANDS-1:0] direct_flags, ctrl_flags;

    function automatic logic [YW-1:0] band_to_line(input logic [BW:0] b);
        return YW'({b, 2'b00});
    endfunction

    dbc_flag_store #(.BANDS(BANDS), .BW(BW), .PGW(PGW)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .mark_valid   (mark_valid),
        .mark_plane   (mark_plane),
        .mark_page    (mark_page),
        .invalidate   (invalidate),
        .clr_en       (clr_en),
        .clr_deep     (deep_q),
        .clr_lo       (lo_q),
        .clr_hi       (hi_q),
        .index_flags  (index_flags),
        .direct_flags (direct_flags),
        .ctrl_flags   (ctrl_flags)
    );

    dbc_band_dirty #(.BANDS(BANDS), .BW(BW)) u_combine (
        .index_flags  (index_flags),
        .direct_flags (direct_flags),
        .ctrl_flags   (ctrl_flags),
        .deep         (deep_q),
        .band         (band_q),
        .band_dirty   (band_dirty)
    );

    assign at_last = (band_q == BW'(BANDS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (scan_start) state_d = ST_SCAN;
            ST_SCAN: begin
                if ((band_dirty && at_last) || (!band_dirty && run_open_q))
                    state_d = ST_EMIT;
                else if (!band_dirty && at_last)
                    state_d = ST_CLEAR;
            end
            ST_EMIT:  if (rect_ready) state_d = last_q ? ST_CLEAR : ST_SCAN;
            ST_CLEAR: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q      <= '0;
            run_start_q <= '0;
            run_open_q  <= 1'b0;
            any_q       <= 1'b0;
            lo_q        <= '0;
            hi_q        <= '0;
            deep_q      <= 1'b0;
            last_q      <= 1'b0;
            done_q      <= 1'b0;
            rect_y_q    <= '0;
            rect_h_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (scan_start) begin
                    band_q     <= '0;
                    run_open_q <= 1'b0;
                    any_q      <= 1'b0;
                    last_q     <= 1'b0;
                    deep_q     <= deep_mode;
                    done_q     <= 1'b0;
                end
                ST_SCAN: begin
                    if (band_dirty) begin
                        any_q <= 1'b1;
                        hi_q  <= band_q;
                        if (!any_q) lo_q <= band_q;
                        if (at_last) begin
                            rect_y_q   <= band_to_line({1'b0, run_open_q ? run_start_q : band_q});
                            rect_h_q   <= band_to_line((BW+1)'(BANDS) -
                                          {1'b0, run_open_q ? run_start_q : band_q});
                            run_open_q <= 1'b0;
                            last_q     <= 1'b1;
                        end else begin
                            if (!run_open_q) begin
                                run_start_q <= band_q;
                                run_open_q  <= 1'b1;
                            end
                            band_q <= band_q + 1'b1;
                        end
                    end else begin
                        if (run_open_q) begin
                            rect_y_q   <= band_to_line({1'b0, run_start_q});
                            rect_h_q   <= band_to_line({1'b0, band_q} - {1'b0, run_start_q});
                            run_open_q <= 1'b0;
                            last_q     <= at_last;
                        end
                        if (!at_last) band_q <= band_q + 1'b1;
                    end
                end
                ST_EMIT:  ;
                ST_CLEAR: done_q <= 1'b1;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rect_valid  = (state_q == ST_EMIT);
        rect_x      = '0;
        rect_w      = WW'(DISP_W);
        rect_y      = rect_y_q;
        rect_h      = rect_h_q;
        clr_en      = (state_q == ST_CLEAR) && any_q;
        scan_busy   = (state_q != ST_IDLE);
        scan_done   = done_q;
        range_valid = done_q && any_q;
        range_lo    = lo_q;
        range_hi    = hi_q;
    end

    // R10: an offered rectangle is held until taken
    p_hold_rect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_valid && !rect_ready) |=> rect_valid && $stable(rect_y) && $stable(rect_h));

    // R1: four-line grid
    p_line_grid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> (rect_y[1:0] == 2'b00) && (rect_h[1:0] == 2'b00) && (rect_h != '0));

    // R2: rectangle fits inside the display
    p_fits_display_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> ((YW+1)'(rect_y) + (YW+1)'(rect_h)) <= (YW+1)'(DISP_LINES));

    // R5: ordered range
    p_range_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        range_valid |-> (range_lo <= range_hi));

    // R9: done never seen during a scan
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> !scan_done);
endmodule

// File: tb/test_dirty_band_coalescer.sv
module test_dirty_band_coalescer;
    localparam int LINES = 64;
    localparam int WIDE  = 1024;
    localparam int BANDS = LINES / 4;
    localparam int PAGES = 4 * BANDS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deep_mode = 1'b0;
    logic       mark_valid = 1'b0;
    logic [1:0] mark_plane = '0;
    logic [5:0] mark_page = '0;
    logic       invalidate = 1'b0;
    logic       scan_start = 1'b0;
    logic       rect_ready = 1'b1;
    logic       rect_valid, range_valid, scan_busy, scan_done;
    logic [10:0] rect_x, rect_w;
    logic [6:0]  rect_y, rect_h;
    logic [3:0]  range_lo, range_hi;

    dirty_band_coalescer #(.DISP_LINES(LINES), .DISP_W(WIDE)) i_dirty_band_coalescer (
        .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode), .mark_valid(mark_valid),
        .mark_plane(mark_plane), .mark_page(mark_page), .invalidate(invalidate),
        .scan_start(scan_start), .rect_valid(rect_valid), .rect_ready(rect_ready),
        .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
        .range_valid(range_valid), .range_lo(range_lo), .range_hi(range_hi),
        .scan_busy(scan_busy), .scan_done(scan_done)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_y[$];
    int exp_h[$];
    bit m_idx[BANDS];
    bit m_dir[PAGES];
    bit m_ctl[PAGES];
    bit stall = 1'b0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // ready pattern, changed just after the edge
    always @(posedge clk) begin
        cyc++;
        #1 rect_ready = stall ? (cyc % 3 == 0) : 1'b1;
    end

    // monitor: pop and compare each accepted rectangle
    always @(negedge clk) begin
        if (rst_n && rect_valid && rect_ready) begin
            if (exp_y.size() == 0) begin
                chk(1'b0, "R2 unexpected rectangle", int'(rect_y), -1);
            end else begin
                int ey, eh;
                ey = exp_y.pop_front();
                eh = exp_h.pop_front();
                chk(int'(rect_y) == ey, "R2 rect_y", int'(rect_y), ey);
                chk(int'(rect_h) == eh, "R3 rect_h", int'(rect_h), eh);
                chk(rect_x == 0 && int'(rect_w) == WIDE, "R4 rect x/w", int'(rect_w), WIDE);
            end
        end
    end

    task automatic mark(input int plane, input int page);
        @(negedge clk);
        mark_valid = 1'b1; mark_plane = 2'(plane); mark_page = 6'(page);
        if (plane == 0 && page < BANDS) m_idx[page] = 1'b1;
        if (plane == 1) m_dir[page] = 1'b1;
        if (plane == 2) m_ctl[page] = 1'b1;
        @(negedge clk);
        mark_valid = 1'b0;
    endtask

    task automatic do_invalidate();
        @(negedge clk);
        invalidate = 1'b1;
        for (int b = 0; b < BANDS; b++) m_idx[b] = 1'b1;
        for (int p = 0; p < PAGES; p++) begin m_dir[p] = 1'b1; m_ctl[p] = 1'b1; end
        @(negedge clk);
        invalidate = 1'b0;
    endtask

    // builds the expected rectangles and range, runs a scan, checks the range, updates the model
    task automatic run_scan(input bit deep, input bit restart, input string tag);
        int start, lo, hi;
        bit any;
        start = -1; lo = 0; hi = 0; any = 1'b0;
        for (int b = 0; b < BANDS; b++) begin
            bit d;
            d = m_idx[b];
            if (deep) for (int k = 0; k < 4; k++) d = d | m_dir[4*b+k] | m_ctl[4*b+k];
            if (d) begin
                if (!any) lo = b;
                hi = b; any = 1'b1;
                if (start < 0) start = b;
            end else if (start >= 0) begin
                exp_y.push_back(4*start); exp_h.push_back(4*(b-start)); start = -1;
            end
        end
        if (start >= 0) begin exp_y.push_back(4*start); exp_h.push_back(LINES - 4*start); end

        @(negedge clk);
        deep_mode = deep; scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        chk(scan_busy && !scan_done, {"R9 busy after start ", tag}, int'(scan_busy), 1);
        if (restart) begin
            @(negedge clk); scan_start = 1'b1;
            @(negedge clk); scan_start = 1'b0;
        end
        while (!scan_done) @(negedge clk);
        chk(!scan_busy, {"R9 idle when done ", tag}, int'(scan_busy), 0);
        chk(exp_y.size() == 0, {"R2 all rectangles seen ", tag}, exp_y.size(), 0);
        chk(range_valid == any, {"R5 range_valid ", tag}, int'(range_valid), int'(any));
        if (any) begin
            chk(int'(range_lo) == lo, {"R5 range_lo ", tag}, int'(range_lo), lo);
            chk(int'(range_hi) == hi, {"R5 range_hi ", tag}, int'(range_hi), hi);
            for (int b = lo; b <= hi; b++) m_idx[b] = 1'b0;
            if (deep) for (int p = 4*lo; p <= 4*hi+3; p++) begin m_dir[p] = 1'b0; m_ctl[p] = 1'b0; end
        end
        repeat (3) @(negedge clk);
        chk(scan_done, {"R9 done held ", tag}, int'(scan_done), 1);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rect_valid && !scan_busy && !scan_done && !range_valid, "R9 reset state",
            int'(scan_busy), 0);

        run_scan(1'b0, 1'b0, "empty");                     // R5 R6 nothing dirty

        mark(0, 2); mark(0, 3); mark(0, 4); mark(0, 9); mark(0, 15);
        run_scan(1'b0, 1'b0, "runs");                      // R1 R2 R3 R4
        run_scan(1'b0, 1'b0, "after clear");               // R6 flags gone

        do_invalidate();
        stall = 1'b1;
        run_scan(1'b0, 1'b0, "invalidate base");           // R8 R10, base-mode scan
        run_scan(1'b1, 1'b0, "invalidate deep planes");    // R6 deep planes kept by base clear
        stall = 1'b0;

        mark(1, 13); mark(2, 22); mark(0, 6);
        run_scan(1'b0, 1'b0, "deep ignored in base");      // R7 base mode ignores wide planes
        run_scan(1'b1, 1'b0, "deep combine");              // R7 R6

        mark(3, 5); mark(0, 20);
        run_scan(1'b0, 1'b0, "ignored marks");             // R11

        mark(1, 60);
        run_scan(1'b1, 1'b0, "deep last band");            // R3 R7

        mark(0, 0); mark(0, 15);
        stall = 1'b1;
        run_scan(1'b0, 1'b1, "restart ignored");           // R9 start while busy
        stall = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule